// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Unit

This block keeps the sticky event flags of an eight-channel DMA engine and turns them into one interrupt request per channel. Each channel reports three kinds of event as single-cycle pulses: a finished transfer, a transfer that has reached its halfway point, and a transfer error. The block records each pulse in a flag. It also keeps a summary flag per channel that is high while any of that channel's three event flags is high.

Software sees all flags through one packed, read-only status word. It removes flags by writing a clear word that uses the same bit layout. A 1 in the clear word removes the matching flag and a 0 leaves it alone. The summary bit position in the clear word removes all of that channel's flags at once. Per-channel enables pick which flags may raise the channel's interrupt line. The bus decoder and the transfer engine sit outside this block.

Top module: `dma_irq_flags`

## Requirements
- R1: After a synchronous active-low reset, every status bit is 0 and every interrupt line is low.
- R2: Channel c (0-based) uses status bits 4c to 4c+3. Bit 4c is the summary flag, 4c+1 is transfer complete, 4c+2 is half transfer and 4c+3 is transfer error.
- R3: An event pulse sets its flag at the next clock edge. The flag then stays set until a clear removes it.
- R4: When `clr_we` is high, a 1 in bit 4c+1, 4c+2 or 4c+3 of `clr_word` clears that one flag at the next edge. Zero bits, and any word presented while `clr_we` is low, change nothing.
- R5: A 1 in bit 4c of an active clear word clears all three event flags of channel c, and so its summary flag. Other channels are untouched.
- R6: If an event pulse and a clear of the same flag arrive in the same cycle, the flag is set after the edge.
- R7: A channel's summary flag is 1 exactly when at least one of its three event flags is 1.
- R8: `irq[c]` is high, in the same cycle, exactly when some event flag of channel c is set and its enable (`ie_tc`, `ie_ht` or `ie_te`) is high.
- R9: Events, clears and enables of one channel never affect another channel's flags or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tc | input | 8 | Transfer-complete event pulse per channel |
| evt_ht | input | 8 | Half-transfer event pulse per channel |
| evt_te | input | 8 | Transfer-error event pulse per channel |
| clr_we | input | 1 | Clear word strobe |
| clr_word | input | 32 | Write-one-to-clear word, same layout as status |
| ie_tc | input | 8 | Transfer-complete interrupt enable per channel |
| ie_ht | input | 8 | Half-transfer interrupt enable per channel |
| ie_te | input | 8 | Transfer-error interrupt enable per channel |
| status | output | 32 | Packed flag word |
| irq | output | 8 | Interrupt request per channel |

## Verification
The bench targets these cases:
- An event and a clear of the same flag in one cycle. A design that gave the clear priority would lose the event.
- A specific clear of one flag while a sibling flag stays set. A wrong summary derivation would drop the summary bit too early, or keep it after the last flag goes.
- The summary clear bit. A design that decoded it as an ordinary flag would leave the other flags set.
- A clear word presented with the strobe low. This must change nothing.
- Interrupt lines under toggling enables with flags held. These expose missing gating or crossed channel wiring.

// File: rtl/dma_irq_pkg.sv
// Package: shared bit positions for the per-channel flag nibble.
// Assumes each channel owns four adjacent status bits.
package dma_irq_pkg;
    localparam int unsigned FLAGS_PER_CH = 4;
    localparam int unsigned POS_SUM      = 0;
    localparam int unsigned POS_TC       = 1;
    localparam int unsigned POS_HT       = 2;
    localparam int unsigned POS_TE       = 3;
endpackage

// File: rtl/dma_flag_chan.sv
// Module: dma_flag_chan
// Holds the three sticky event flags of one channel and derives its summary flag.
// Assumes event inputs are single-cycle pulses and clr_nib is only acted on
// when clr_en is high. A set and a clear of the same flag in one cycle: set wins.
module dma_flag_chan
    import dma_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_tc,
    input  logic                    evt_ht,
    input  logic                    evt_te,
    input  logic                    clr_en,
    input  logic [FLAGS_PER_CH-1:0] clr_nib,
    output logic [FLAGS_PER_CH-1:0] flags
);
    logic tc_q, ht_q, te_q;
    logic kill_all, kill_tc, kill_ht, kill_te;

    // Decode which flags the clear word removes this cycle.
    always_comb begin
        kill_all = clr_en & clr_nib[POS_SUM];
        kill_tc  = kill_all | (clr_en & clr_nib[POS_TC]);
        kill_ht  = kill_all | (clr_en & clr_nib[POS_HT]);
        kill_te  = kill_all | (clr_en & clr_nib[POS_TE]);
    end

    // Update the sticky flags: a pulse sets, a clear removes, the pulse has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
            ht_q <= 1'b0;
            te_q <= 1'b0;
        end else begin
            tc_q <= evt_tc | (tc_q & ~kill_tc);
            ht_q <= evt_ht | (ht_q & ~kill_ht);
            te_q <= evt_te | (te_q & ~kill_te);
        end
    end

    // Pack the nibble, with the summary bit as the OR of the event flags.
    always_comb begin
        flags           = '0;
        flags[POS_TC]   = tc_q;
        flags[POS_HT]   = ht_q;
        flags[POS_TE]   = te_q;
        flags[POS_SUM]  = tc_q | ht_q | te_q;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tc |=> flags[POS_TC]);
    // R4
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_nib[POS_TC] && !evt_tc) |=> !flags[POS_TC]);
    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_nib[POS_SUM] && !evt_tc && !evt_ht && !evt_te) |=> (flags == '0));
    // R3
    sticky_te_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[POS_TE] && !(clr_en && (clr_nib[POS_TE] || clr_nib[POS_SUM]))) |=> flags[POS_TE]);
endmodule

// File: rtl/dma_irq_gate.sv
// Module: dma_irq_gate
// Combines one channel's event flags with their enables into a request line.
// Assumes flags come from dma_flag_chan, with the summary in bit POS_SUM.
module dma_irq_gate
    import dma_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FLAGS_PER_CH-1:0] flags,
    input  logic                    ie_tc,
    input  logic                    ie_ht,
    input  logic                    ie_te,
    output logic                    irq
);
    // Raise the request when any enabled flag is set.
    always_comb begin
        irq = (flags[POS_TC] & ie_tc) | (flags[POS_HT] & ie_ht) | (flags[POS_TE] & ie_te);
    end

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags[POS_SUM]);
endmodule

// File: rtl/dma_irq_flags.sv
// Module: dma_irq_flags (top)
// Per-channel DMA event flags, packed status word, write-one-to-clear word
// and enable-gated per-channel interrupt lines. Assumes the bus decoder
// presents clr_word with a one-cycle clr_we strobe.
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned STAT_W = NUM_CH * FLAGS_PER_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_tc,
    input  logic [NUM_CH-1:0] evt_ht,
    input  logic [NUM_CH-1:0] evt_te,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_word,
    input  logic [NUM_CH-1:0] ie_tc,
    input  logic [NUM_CH-1:0] ie_ht,
    input  logic [NUM_CH-1:0] ie_te,
    output logic [STAT_W-1:0] status,
    output logic [NUM_CH-1:0] irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [FLAGS_PER_CH-1:0] nib;

        dma_flag_chan u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_tc  (evt_tc[c]),
            .evt_ht  (evt_ht[c]),
            .evt_te  (evt_te[c]),
            .clr_en  (clr_we),
            .clr_nib (clr_word[c*FLAGS_PER_CH +: FLAGS_PER_CH]),
            .flags   (nib)
        );

        dma_irq_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .flags (nib),
            .ie_tc (ie_tc[c]),
            .ie_ht (ie_ht[c]),
            .ie_te (ie_te[c]),
            .irq   (irq[c])
        );

        assign status[c*FLAGS_PER_CH +: FLAGS_PER_CH] = nib;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0));
endmodule

// File: tb/dma_irq_flags_tb.sv
module dma_irq_flags_tb;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] evt_tc = '0, evt_ht = '0, evt_te = '0;
    logic [NCH-1:0] ie_tc = '0, ie_ht = '0, ie_te = '0;
    logic clr_we = 1'b0;
    logic [31:0] clr_word = '0;
    logic [31:0] status;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state: one bit per channel and event kind.
    bit m_tc[NCH], m_ht[NCH], m_te[NCH];

    always #2.5 clk = ~clk;

    dma_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_tc(evt_tc), .evt_ht(evt_ht), .evt_te(evt_te),
        .clr_we(clr_we), .clr_word(clr_word),
        .ie_tc(ie_tc), .ie_ht(ie_ht), .ie_te(ie_te),
        .status(status), .irq(irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        for (int c = 0; c < NCH; c++) begin
            s[4*c+1] = m_tc[c];
            s[4*c+2] = m_ht[c];
            s[4*c+3] = m_te[c];
            s[4*c]   = m_tc[c] || m_ht[c] || m_te[c];
        end
        return s;
    endfunction

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] r = '0;
        for (int c = 0; c < NCH; c++)
            r[c] = (m_tc[c] && ie_tc[c]) || (m_ht[c] && ie_ht[c]) || (m_te[c] && ie_te[c]);
        return r;
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply the current inputs for one edge, advance the model, compare.
    task automatic step(string tag);
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            bit all_c = clr_we && clr_word[4*c];
            m_tc[c] = evt_tc[c] || (m_tc[c] && !(all_c || (clr_we && clr_word[4*c+1])));
            m_ht[c] = evt_ht[c] || (m_ht[c] && !(all_c || (clr_we && clr_word[4*c+2])));
            m_te[c] = evt_te[c] || (m_te[c] && !(all_c || (clr_we && clr_word[4*c+3])));
        end
        check32({tag, " status"}, status, exp_status());
        check32({tag, " irq"}, {24'd0, irq}, {24'd0, exp_irq()});
        evt_tc = '0; evt_ht = '0; evt_te = '0; clr_we = 1'b0; clr_word = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_tc[c] = 0; m_ht[c] = 0; m_te[c] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check32("R1 status", status, 32'h0);
        check32("R1 irq", {24'd0, irq}, 32'h0);
        rst_n = 1'b1;

        // R2 layout: channel index 2 transfer-complete -> bits 9 and 8
        evt_tc[2] = 1'b1; step("R2");
        check32("R2 layout", status, 32'h0000_0300);
        // R3 sticky across idle cycles
        step("R3"); step("R3");
        // R2 error on channel 7 -> bits 31 and 28
        evt_te[7] = 1'b1; step("R2 te");
        check32("R2 te layout", status, 32'h9000_0300);
        // R4 word presented with strobe low does nothing
        clr_word = 32'hFFFF_FFFF; step("R4 no strobe");
        // R7 half flag on ch2, then clear only tc: summary stays
        evt_ht[2] = 1'b1; step("R7");
        clr_we = 1; clr_word = 32'h0000_0200; step("R7 partial");
        check32("R7 summary kept", status & 32'h0000_0F00, 32'h0000_0500);
        clr_we = 1; clr_word = 32'h0000_0400; step("R7 last");
        check32("R7 summary drops", status & 32'h0000_0F00, 32'h0);
        // R6 set and clear together
        evt_ht[4] = 1'b1; clr_we = 1; clr_word = 32'h0004_0000; step("R6");
        check32("R6 set wins", status & 32'h000F_0000, 32'h0005_0000);
        // R5 clear-all on channel 4 only
        evt_tc[4] = 1; evt_te[4] = 1; evt_tc[3] = 1; step("R5 fill");
        clr_we = 1; clr_word = 32'h0001_0000; step("R5");
        check32("R5 others intact", status & 32'h000F_F000, 32'h0000_3000);
        // R8 / R9 enables
        ie_te = 8'h80; step("R8 te");
        ie_te = 8'h00; ie_tc = 8'h04; step("R8 unflagged");
        ie_tc = 8'h08; step("R9 ch3");
        ie_tc = 8'hFF; ie_ht = 8'hFF; ie_te = 8'hFF; step("R8 all");

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            evt_tc = $urandom & $urandom & $urandom;
            evt_ht = $urandom & $urandom & $urandom;
            evt_te = $urandom & $urandom & $urandom;
            clr_we = ($urandom % 3) == 0;
            clr_word = $urandom & $urandom;
            ie_tc = $urandom; ie_ht = $urandom; ie_te = $urandom;
            step("R3 R4 R5 R6 R9 mix");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule